// File: doc/BRIEF.md
# SPI Receive Double Buffer with Status Word

This block sits between an SPI shift engine and a host bus. Each completed transfer hands it a received word, the number of the chip select that was active, and five error flags. The block keeps these in two stages. An internal stage absorbs the newest arrival. A host-visible stage feeds a 32-bit read-only status word. That word packs the visible data, the chip-select number, the error flags of that transfer, an empty flag, an overrun flag and a transmit-full flag.

A host read of the word consumes the visible entry and promotes the internal stage into its place. A write-1-to-clear of the receive interrupt flag consumes the entry in the same way, and the pending word is then treated as discarded. When a word arrives while both stages are occupied, only the internal stage is overwritten and the overrun flag is raised. The host therefore needs two reads to reach the overwriting word. On the transmit side, one holding word waits in front of the shift register, and the transmit-full flag reports whether that holding word is in use.

Top module: `spi_rxbuf_stat`

## Requirements
- R1: After synchronous reset the status word reads 32'h8000_0000: the empty flag (bit 31) is 1 and every other field is 0. `ovr_irq` and `shift_valid` are 0.
- R2: A transfer completion while both stages are empty is visible one cycle later. Bits 15:0 hold the data, bits 23:16 hold the chip select, bits 28:24 hold the error flags, and bit 31 is 0.
- R3: A host read (`host_rd`) while only the visible stage is full sets bit 31 to 1 in the following cycle.
- R4: A pulse on `rxflag_clr` consumes the visible entry exactly as a read does, setting bit 31 or promoting the internal stage. It leaves the overrun flag (bit 30) unchanged.
- R5: A completion while the visible stage is full and the internal stage is empty goes into the internal stage. The visible fields do not change until the next read or clear.
- R6: A completion while both stages are full overwrites the internal stage and sets bit 30. The visible fields are not changed.
- R7: After an overrun, the first read presents the word that was already visible and clears bit 30. The word that did the overwriting appears as the visible entry after that first read.
- R8: Error flags map as bit 28 bit error, bit 27 desynchronisation, bit 26 parity error, bit 25 timeout and bit 24 data-length error. On `xfer_err` they map as bit 4 down to bit 0 in the same order. A completion that carries errors into full stages sets bit 30 like any overrun.
- R9: When a read or clear and a completion occur in the same cycle, the consume is applied first. The arriving word takes the freed place, and no overrun is flagged.
- R10: `ovr_irq` is high exactly when bit 30 is 1 and `ovr_irq_en` is 1.
- R11: A transmit write while the shift register and the holding word are both empty loads the shift register directly. `shift_valid` and `shift_word` follow one cycle later, and bit 29 stays 0.
- R12: A transmit write while the shift register is occupied sets bit 29. On `shift_done` the held word moves into the shift register and bit 29 returns to 0. A `shift_done` with no held word empties the shift register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xfer_done | input | 1 | Transfer-complete strobe from the shift engine |
| xfer_data | input | 16 | Received data word |
| xfer_cs | input | 8 | Chip-select number of the completed transfer |
| xfer_err | input | 5 | Error flags: bit error, desync, parity, timeout, length (bit 4 to 0) |
| host_rd | input | 1 | Host read of the status word's data field |
| rxflag_clr | input | 1 | Write-1-to-clear of the receive interrupt flag |
| ovr_irq_en | input | 1 | Overrun interrupt enable |
| tx_wr | input | 1 | Host write of a transmit word |
| tx_wdata | input | 16 | Transmit word |
| shift_done | input | 1 | Shift register has finished with its word |
| status_word | output | 32 | Packed read-only status and visible received data |
| ovr_irq | output | 1 | Overrun interrupt |
| shift_valid | output | 1 | Shift register holds a word |
| shift_word | output | 16 | Word currently in the shift register |

## Verification
Every stage and the transmit path are registered. A completion, read, clear or transmit write therefore shows on `status_word`, `shift_valid` and `shift_word` exactly one clock edge after the cycle in which its strobe is held. `ovr_irq` additionally follows `ovr_irq_en` in the same cycle. The bench drives each strobe for one cycle just after a rising edge and compares all outputs one nanosecond after the next rising edge. At that point the reference model has applied the same cycle's inputs, so every check lands on the cycle in which its result is due.

// File: rtl/spi_rxs_pkg.sv
package spi_rxs_pkg;

    localparam int DATA_W = 16;
    localparam int CS_W   = 8;
    localparam int ERR_N  = 5;
    localparam int STAT_W = 3 + ERR_N + CS_W + DATA_W;

    // Error flags, most significant first as they sit in the status word.
    typedef struct packed {
        logic bit_err;
        logic desync;
        logic parity;
        logic timeout;
        logic len_err;
    } err_t;

    typedef struct packed {
        logic [CS_W-1:0]   cs;
        err_t              err;
        logic [DATA_W-1:0] data;
    } rx_word_t;

    function automatic logic [STAT_W-1:0] pack_status(
        input logic     empty,
        input logic     ovr,
        input logic     txfull,
        input rx_word_t w
    );
        return {empty, ovr, txfull, w.err, w.cs, w.data};
    endfunction

endpackage

// File: rtl/spi_rx_stage2.sv
module spi_rx_stage2
    import spi_rxs_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     done_i,
    input  rx_word_t in_word_i,
    input  logic     rd_i,
    input  logic     clr_i,
    output rx_word_t vis_word_o,
    output logic     vis_full_o,
    output logic     ovr_o
);

    rx_word_t a_q, b_q, a_n, b_n;
    logic     af_q, bf_q, ovr_q;
    logic     af_n, bf_n, ovr_n;

    always_comb begin
        a_n   = a_q;
        b_n   = b_q;
        af_n  = af_q;
        bf_n  = bf_q;
        ovr_n = ovr_q;
        // consume first so a same-cycle arrival lands in the freed place
        if (rd_i || clr_i) begin
            if (af_q) begin
                b_n  = a_q;
                bf_n = 1'b1;
                af_n = 1'b0;
            end else begin
                bf_n = 1'b0;
            end
        end
        if (rd_i) ovr_n = 1'b0;
        if (done_i) begin
            if (!bf_n) begin
                b_n  = in_word_i;
                bf_n = 1'b1;
            end else begin
                a_n = in_word_i;
                if (af_n) ovr_n = 1'b1;
                af_n = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            a_q   <= '0;
            b_q   <= '0;
            af_q  <= 1'b0;
            bf_q  <= 1'b0;
            ovr_q <= 1'b0;
        end else begin
            a_q   <= a_n;
            b_q   <= b_n;
            af_q  <= af_n;
            bf_q  <= bf_n;
            ovr_q <= ovr_n;
        end
    end

    assign vis_word_o = b_q;
    assign vis_full_o = bf_q;
    assign ovr_o      = ovr_q;

    AST_INNER_NEEDS_VISIBLE: assert property (@(posedge clk) disable iff (rst)
        af_q |-> bf_q); // R5
    AST_VISIBLE_HELD: assert property (@(posedge clk) disable iff (rst)
        (bf_q && !rd_i && !clr_i) |=> (bf_q && $stable(b_q))); // R6
    AST_OVR_ONLY_WHEN_FULL: assert property (@(posedge clk) disable iff (rst)
        $rose(ovr_q) |-> $past(af_q && bf_q && done_i && !rd_i && !clr_i)); // R9
    AST_READ_CLEARS_OVR: assert property (@(posedge clk) disable iff (rst)
        rd_i |=> !ovr_q); // R7

endmodule

// File: rtl/spi_tx_hold.sv
module spi_tx_hold #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_i,
    input  logic [W-1:0] wdata_i,
    input  logic         sh_done_i,
    output logic         sh_valid_o,
    output logic [W-1:0] sh_word_o,
    output logic         tx_full_o
);

    logic [W-1:0] sh_q, hold_q, sh_n, hold_n;
    logic         shf_q, full_q, shf_n, full_n;

    always_comb begin
        sh_n   = sh_q;
        hold_n = hold_q;
        shf_n  = shf_q;
        full_n = full_q;
        if (sh_done_i && shf_q) begin
            if (full_q) begin
                sh_n   = hold_q;
                full_n = 1'b0;
            end else begin
                shf_n = 1'b0;
            end
        end
        if (wr_i) begin
            if (!shf_n) begin
                sh_n  = wdata_i;
                shf_n = 1'b1;
            end else begin
                hold_n = wdata_i;
                full_n = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q   <= '0;
            hold_q <= '0;
            shf_q  <= 1'b0;
            full_q <= 1'b0;
        end else begin
            sh_q   <= sh_n;
            hold_q <= hold_n;
            shf_q  <= shf_n;
            full_q <= full_n;
        end
    end

    assign sh_valid_o = shf_q;
    assign sh_word_o  = sh_q;
    assign tx_full_o  = full_q;

    AST_HOLD_NEEDS_SHIFT: assert property (@(posedge clk) disable iff (rst)
        full_q |-> shf_q); // R12
    AST_DIRECT_LOAD: assert property (@(posedge clk) disable iff (rst)
        (wr_i && !shf_q) |=> (shf_q && !full_q && sh_q == $past(wdata_i))); // R11

endmodule

// File: rtl/spi_rxbuf_stat.sv
module spi_rxbuf_stat
    import spi_rxs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              xfer_done,
    input  logic [DATA_W-1:0] xfer_data,
    input  logic [CS_W-1:0]   xfer_cs,
    input  logic [ERR_N-1:0]  xfer_err,
    input  logic              host_rd,
    input  logic              rxflag_clr,
    input  logic              ovr_irq_en,
    input  logic              tx_wr,
    input  logic [DATA_W-1:0] tx_wdata,
    input  logic              shift_done,
    output logic [STAT_W-1:0] status_word,
    output logic              ovr_irq,
    output logic              shift_valid,
    output logic [DATA_W-1:0] shift_word
);

    rx_word_t in_w, vis_w;
    logic     vis_full, ovr, tx_full;

    always_comb begin
        in_w.data = xfer_data;
        in_w.cs   = xfer_cs;
        in_w.err  = err_t'(xfer_err);
    end

    spi_rx_stage2 u_rx (
        .clk        (clk),
        .rst        (rst),
        .done_i     (xfer_done),
        .in_word_i  (in_w),
        .rd_i       (host_rd),
        .clr_i      (rxflag_clr),
        .vis_word_o (vis_w),
        .vis_full_o (vis_full),
        .ovr_o      (ovr)
    );

    spi_tx_hold #(.W(DATA_W)) u_tx (
        .clk        (clk),
        .rst        (rst),
        .wr_i       (tx_wr),
        .wdata_i    (tx_wdata),
        .sh_done_i  (shift_done),
        .sh_valid_o (shift_valid),
        .sh_word_o  (shift_word),
        .tx_full_o  (tx_full)
    );

    assign status_word = pack_status(!vis_full, ovr, tx_full, vis_w);
    assign ovr_irq     = ovr && ovr_irq_en;

    AST_IRQ_FOLLOWS_FLAG: assert property (@(posedge clk) disable iff (rst)
        ovr_irq |-> status_word[30]); // R10

endmodule

// File: tb/spi_rxbuf_stat_tb.sv
`timescale 1ns/1ps
module spi_rxbuf_stat_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        xfer_done = 0, host_rd = 0, rxflag_clr = 0, ovr_irq_en = 0;
    logic        tx_wr = 0, shift_done = 0;
    logic [15:0] xfer_data = 0, tx_wdata = 0;
    logic [7:0]  xfer_cs = 0;
    logic [4:0]  xfer_err = 0;
    logic [31:0] status_word;
    logic        ovr_irq, shift_valid;
    logic [15:0] shift_word;

    int n_run = 0, n_fail = 0;

    always #5 clk = ~clk;

    spi_rxbuf_stat dut_i (
        .clk(clk), .rst(rst), .xfer_done(xfer_done), .xfer_data(xfer_data),
        .xfer_cs(xfer_cs), .xfer_err(xfer_err), .host_rd(host_rd),
        .rxflag_clr(rxflag_clr), .ovr_irq_en(ovr_irq_en), .tx_wr(tx_wr),
        .tx_wdata(tx_wdata), .shift_done(shift_done), .status_word(status_word),
        .ovr_irq(ovr_irq), .shift_valid(shift_valid), .shift_word(shift_word)
    );

    // reference state
    logic        m_bf, m_af, m_ovr, m_shf, m_txf;
    logic [28:0] m_b, m_a;      // {err, cs, data}
    logic [15:0] m_sh, m_hold;

    task automatic model_reset();
        m_bf = 0; m_af = 0; m_ovr = 0; m_shf = 0; m_txf = 0;
        m_b = 0; m_a = 0; m_sh = 0; m_hold = 0;
    endtask

    task automatic model_step();
        logic [28:0] inw;
        inw = {xfer_err, xfer_cs, xfer_data};
        if (host_rd || rxflag_clr) begin
            if (m_af) begin m_b = m_a; m_bf = 1; m_af = 0; end
            else m_bf = 0;
        end
        if (host_rd) m_ovr = 0;
        if (xfer_done) begin
            if (!m_bf) begin m_b = inw; m_bf = 1; end
            else begin m_a = inw; if (m_af) m_ovr = 1; m_af = 1; end
        end
        if (shift_done && m_shf) begin
            if (m_txf) begin m_sh = m_hold; m_txf = 0; end
            else m_shf = 0;
        end
        if (tx_wr) begin
            if (!m_shf) begin m_sh = tx_wdata; m_shf = 1; end
            else begin m_hold = tx_wdata; m_txf = 1; end
        end
    endtask

    function automatic logic [31:0] exp_status();
        return {!m_bf, m_ovr, m_txf, m_b};
    endfunction

    function automatic logic [17:0] exp_side();
        return {m_ovr && ovr_irq_en, m_shf, m_shf ? m_sh : 16'h0};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        check(tag, status_word, exp_status());
        check(tag, {14'h0, ovr_irq, shift_valid, shift_valid ? shift_word : 16'h0},
              {14'h0, exp_side()});
    endtask

    // one cycle: inputs already set, take edge, update model, clear strobes
    task automatic step();
        @(posedge clk);
        #1;
        model_step();
        xfer_done = 0; host_rd = 0; rxflag_clr = 0; tx_wr = 0; shift_done = 0;
    endtask

    task automatic rx(input logic [15:0] d, input logic [7:0] c, input logic [4:0] e);
        xfer_done = 1; xfer_data = d; xfer_cs = c; xfer_err = e;
    endtask

    initial begin
        #1_000_000;
        n_fail++;
        $display("FAIL watchdog: run did not finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        #1 rst = 0;
        check("R1 reset status", status_word, 32'h8000_0000);
        check("R1 reset side", {30'h0, ovr_irq, shift_valid}, 32'h0);

        rx(16'h00A1, 8'h03, 5'h00); step();
        check("R2 first word", status_word, 32'h0003_00A1);
        host_rd = 1; step();
        check("R3 read empties", status_word, 32'h8003_00A1);

        rx(16'h1111, 8'h01, 5'h00); step();
        rx(16'h2222, 8'h01, 5'h00); step();
        check("R5 inner holds second", status_word, 32'h0001_1111);
        rx(16'h3333, 8'h02, 5'b00010); step();
        check("R6 R8 overrun by error word", status_word, 32'h4001_1111);
        ovr_irq_en = 1; #1;
        check("R10 irq enabled", {31'h0, ovr_irq}, 32'h1);
        ovr_irq_en = 0; #1;
        check("R10 irq masked", {31'h0, ovr_irq}, 32'h0);
        host_rd = 1; step();
        check("R7 R8 first read shows overwriting word", status_word, 32'h0202_3333);
        host_rd = 1; step();
        check("R3 empty again", status_word[31:30], 2'b10);

        rx(16'h4444, 8'h04, 5'h00); step();
        rx(16'h5555, 8'h05, 5'h00); step();
        rx(16'h6666, 8'h06, 5'b10101); step();
        rxflag_clr = 1; step();
        check("R4 clear promotes, keeps ovr", status_word, 32'h5506_6666);
        rxflag_clr = 1; step();
        check("R4 clear empties", status_word[31:30], 2'b11);
        host_rd = 1; step();
        check("R7 read clears ovr", status_word[31:30], 2'b10);

        rx(16'h7001, 8'h07, 5'h00); step();
        rx(16'h7002, 8'h07, 5'h00); step();
        host_rd = 1; rx(16'h7003, 8'h07, 5'h00); step();
        check("R9 same-cycle read and arrival", status_word, 32'h0007_7002);
        host_rd = 1; step();
        check("R9 arrival reached visible", status_word, 32'h0007_7003);
        host_rd = 1; step();

        tx_wr = 1; tx_wdata = 16'h1234; step();
        check("R11 direct load", {status_word[29], 14'h0, shift_valid, shift_word},
              {1'b0, 14'h0, 1'b1, 16'h1234});
        tx_wr = 1; tx_wdata = 16'h5678; step();
        check("R12 held word sets full", {status_word[29], 14'h0, shift_valid, shift_word},
              {1'b1, 14'h0, 1'b1, 16'h1234});
        shift_done = 1; step();
        check("R12 moved to shift", {status_word[29], 14'h0, shift_valid, shift_word},
              {1'b0, 14'h0, 1'b1, 16'h5678});
        shift_done = 1; step();
        check("R12 shift emptied", {30'h0, status_word[29], shift_valid}, 32'h0);
        check_all("R1-model sync");

        void'($urandom(32'd20240611));
        for (int i = 0; i < 4000; i++) begin
            xfer_done  = ($urandom % 100) < 45;
            xfer_data  = 16'($urandom);
            xfer_cs    = 8'($urandom);
            xfer_err   = (($urandom % 4) == 0) ? 5'($urandom) : 5'h0;
            host_rd    = ($urandom % 100) < 25;
            rxflag_clr = ($urandom % 100) < 7;
            tx_wr      = ($urandom % 100) < 30;
            tx_wdata   = 16'($urandom);
            shift_done = ($urandom % 100) < 35;
            ovr_irq_en = 1'($urandom);
            step();
            check_all("R6 R9 R12 random");
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule